// File: doc/BRIEF.md
# Restoring Array Divider

This block divides one unsigned integer by another in pure combinational logic and returns only the quotient. It is a triangular array of subtract-and-restore rows. Each row appends one more dividend bit, taken from the most significant end downward, to the running partial remainder. It then subtracts the divisor across a ripple-borrow chain of single-bit subtractor cells. The inverted final borrow of the row is one quotient bit. A rank of 2:1 selectors passes on either the new difference or the unchanged minuend. The result is the partial remainder for the next row. The last row has no selectors, because no remainder leaves the block.

The two operand widths are separate parameters. The working width is the larger of the two, and the narrower operand is zero-extended to it. No clock is involved: the quotient follows the operands through the array's logic depth. A divisor of zero is not an error case. Because no row ever borrows, the quotient comes out as all ones.

Top module: `arr_divider`

## Requirements
- R1: For every nonzero divisor, `quotient` equals the unsigned integer quotient floor(dividend / divisor) of the zero-extended operands, with any remainder discarded.
- R2: When the divisor is zero, every bit of `quotient` is 1, for any dividend.
- R3: The working width is the larger of `DIVIDEND_W` and `DIVISOR_W`, `quotient` has that width, and the narrower operand is zero-extended (treated as unsigned) before division.
- R4: The block holds no state: a change on either operand reaches `quotient` without any clock edge.
- R5: A dividend of all ones divided by a divisor of 1 returns the dividend unchanged, so the widest quotient passes through every row.
- R6: A dividend smaller than a nonzero divisor returns a quotient of 0.
- R7: A nonzero dividend equal to the divisor returns a quotient of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | DIVIDEND_W | Unsigned number to be divided |
| divisor | input | DIVISOR_W | Unsigned number to divide by |
| quotient | output | max(DIVIDEND_W, DIVISOR_W) | Unsigned integer quotient |

## Verification
The bench sweeps every operand pair at width 4, divisor zero included. It then applies random pairs to a width-8 instance with a narrower divisor and to a width-16 instance with a narrower dividend. Directed patterns are mixed into the random ones. A broken restore selector would let the partial remainder go negative. The quotient bits below that row would then be wrong, mostly for divisors near half the dividend. Sign-extending the narrow operand instead of zero-extending it would give wrong results whenever its top bit is set. A borrow chain that drops the seed or the top cell would miss exact divisions (dividend equal to divisor) or misreport a zero divisor.

// File: rtl/div_pkg.sv
package div_pkg;

  // Larger of two operand widths; sets the array's working width.
  function automatic int unsigned wmax(input int unsigned x, input int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sub_cell.sv
// One-bit full subtractor: x - y - bin.
module sub_cell (
  input  logic x,
  input  logic y,
  input  logic bin,
  output logic diff,
  output logic bout
);
  always_comb begin
    diff = x ^ y ^ bin;
    bout = (~x & y) | (~(x ^ y) & bin);
  end
endmodule

// File: rtl/div_row.sv
// One subtract-and-restore row of the array.
module div_row #(
  parameter int unsigned N       = 4,
  parameter bit          HAS_MUX = 1'b1
) (
  input  logic [N-2:0] rem_in,
  input  logic         new_bit,
  input  logic [N-1:0] dvs,
  output logic         quot_bit,
  output logic [N-2:0] rem_out
);
  logic [N-1:0] minu;
  logic [N-1:0] diff;
  logic [N:0]   bor;

  assign minu   = {rem_in, new_bit};
  assign bor[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_cell
    sub_cell u_cell (
      .x    (minu[k]),
      .y    (dvs[k]),
      .bin  (bor[k]),
      .diff (diff[k]),
      .bout (bor[k+1])
    );
  end

  assign quot_bit = ~bor[N];

  if (HAS_MUX) begin : g_restore
    for (genvar k = 0; k < N - 1; k++) begin : g_mux
      assign rem_out[k] = bor[N] ? minu[k] : diff[k];
    end
  end else begin : g_plain
    assign rem_out = diff[N-2:0];
  end

  always_comb begin
    if (!$isunknown({rem_in, new_bit, dvs})) begin
      // R1: a row that does not borrow yields the true difference
      assert_row_diff_R1: assert (bor[N] || (diff == minu - dvs))
        else $error("row difference mismatch");
      // R1: restored remainder of a restoring row stays below the divisor
      assert_row_rem_R1: assert (!HAS_MUX || dvs == '0 || {1'b0, rem_out} < dvs)
        else $error("row remainder not below divisor");
    end
  end
endmodule

// File: rtl/arr_divider.sv
module arr_divider #(
  parameter int unsigned DIVIDEND_W = 8,
  parameter int unsigned DIVISOR_W  = 8,
  localparam int unsigned N = div_pkg::wmax(DIVIDEND_W, DIVISOR_W)
) (
  input  logic [DIVIDEND_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]  divisor,
  output logic [N-1:0]          quotient
);
  localparam int unsigned W2 = 2 * N;

  logic [N-1:0] a_e;
  logic [N-1:0] b_e;
  logic [N-2:0] rem_bus [N+1];

  assign a_e        = N'(dividend);
  assign b_e        = N'(divisor);
  assign rem_bus[N] = '0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_row
    div_row #(
      .N       (N),
      .HAS_MUX (i != 0)
    ) u_row (
      .rem_in   (rem_bus[i+1]),
      .new_bit  (a_e[i]),
      .dvs      (b_e),
      .quot_bit (quotient[i]),
      .rem_out  (rem_bus[i])
    );
  end

  logic [W2-1:0] prod_lo;
  logic [W2-1:0] prod_hi;
  logic [W2-1:0] a_w;
  logic [W2-1:0] left;

  always_comb begin
    a_w     = W2'(a_e);
    prod_lo = W2'(quotient) * W2'(b_e);
    prod_hi = prod_lo + W2'(b_e);
    left    = a_w - prod_lo;
    if (!$isunknown({dividend, divisor})) begin
      assert_q_low_R1: assert (b_e == '0 || prod_lo <= a_w)
        else $error("quotient too large");
      assert_q_high_R1: assert (b_e == '0 || prod_hi > a_w)
        else $error("quotient too small");
      assert_final_diff_R1: assert (b_e == '0 || !quotient[0] ||
                                    rem_bus[0] == left[N-2:0])
        else $error("final row difference mismatch");
      assert_zero_div_R2: assert (b_e != '0 || quotient == '1)
        else $error("divide by zero not all ones");
      assert_equal_R7: assert (a_e != b_e || a_e == '0 || quotient == N'(1))
        else $error("equal operands not one");
    end
  end
endmodule

// File: tb/arr_divider_test.sv
module arr_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]  a4,  b4,  q4;
  logic [7:0]  a8,  q8;
  logic [4:0]  b8;
  logic [11:0] a16;
  logic [15:0] b16, q16;

  arr_divider #(.DIVIDEND_W(4),  .DIVISOR_W(4))  uut
    (.dividend(a4),  .divisor(b4),  .quotient(q4));
  arr_divider #(.DIVIDEND_W(8),  .DIVISOR_W(5))  uut_w8
    (.dividend(a8),  .divisor(b8),  .quotient(q8));
  arr_divider #(.DIVIDEND_W(12), .DIVISOR_W(16)) uut_w16
    (.dividend(a16), .divisor(b16), .quotient(q16));

  function automatic longint unsigned ref_div(longint unsigned a, longint unsigned b,
                                              int w);
    if (b == 0) return (64'd1 << w) - 1;
    return a / b;
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run4(int a, int b, string req);
    @(posedge clk); #1;
    a4 = 4'(a); b4 = 4'(b);
    @(negedge clk);
    check(req, q4, ref_div(a4, b4, 4));
  endtask

  task automatic run8(int a, int b, string req);
    @(posedge clk); #1;
    a8 = 8'(a); b8 = 5'(b);
    @(negedge clk);
    check(req, q8, ref_div(a8, b8, 8));
  endtask

  task automatic run16(int a, int b, string req);
    @(posedge clk); #1;
    a16 = 12'(a); b16 = 16'(b);
    @(negedge clk);
    check(req, q16, ref_div(a16, b16, 16));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    a4 = '0; b4 = '0; a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: zero operands at start give all ones
    check("R2 start", q4, 4'hF);
    check("R2 start w16", q16, 16'hFFFF);

    // R1 R2: exhaustive width 4
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(a, b, (b == 0) ? "R2 sweep" : "R1 sweep");

    // R5 R6 R7 corners
    run4(15, 1, "R5 w4");
    run8(255, 1, "R5 w8");
    run16(4095, 1, "R5 w16");
    run4(3, 9, "R6 w4");
    run16(100, 40000, "R6 w16");
    run8(23, 23, "R7 w8");
    run16(4000, 4000, "R7 w16");
    run8(200, 0, "R2 w8");
    run16(4095, 0, "R2 w16");

    // R3: top bits set on narrow operands must not be sign-extended
    run8(255, 31, "R3 w8 divisor msb");
    run8(128, 16, "R3 w8 divisor msb");
    run16(4095, 3, "R3 w16 dividend msb");
    run16(2048, 2048, "R3 w16 dividend msb");

    // R4: output follows the inputs with no clock edge in between
    @(posedge clk); #1;
    a4 = 4'd12; b4 = 4'd5;
    #1 check("R4 no clock", q4, 4'd2);
    b4 = 4'd3;
    #1 check("R4 no clock", q4, 4'd4);

    // R1: random pairs on the wider instances
    for (int n = 0; n < 2000; n++) begin
      int unsigned ra, rb;
      ra = $urandom; rb = $urandom;
      if (n % 5 == 0) rb = rb % 4;
      run8(int'(ra & 255), int'(rb & 31), "R1 rand w8");
    end
    for (int n = 0; n < 2000; n++) begin
      int unsigned ra, rb;
      ra = $urandom; rb = $urandom;
      if (n % 3 == 0) rb = rb & 16'h00FF;
      if (n % 7 == 0) rb = ra & 12'hFFF;
      run16(int'(ra & 12'hFFF), int'(rb & 16'hFFFF), "R1 rand w16");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule